// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This execution unit serves a general-purpose integer core. It multiplies two 32-bit register operands into a 64-bit product and keeps the architectural HI and LO registers, which hold the upper and lower halves of a 64-bit accumulator. The core dispatches an operation by raising `op_valid` for one cycle. With it the core supplies the 6-bit function code, the 5-bit selector taken from the instruction's shift-amount slot, the destination register index and the two operands.

A zero selector gives the conventional multiply. It only rewrites HI and LO. A legal nonzero selector picks an extended variant, which is accepted only while `ext_enable` is high. An extended variant can negate the product, or add it to or subtract it from the accumulator. In the same operation it hands either the new LO or the new HI back to the register file. Encodings the unit does not recognise are reported through `rsvd_insn` and change no state. HI and LO can always be read on dedicated output ports.

Top module: `mac_hilo_unit`

## Requirements
- R1: After reset HI and LO read zero, and `done`, `rsvd_insn` and `wb_en` are low.
- R2: Function code 0x18 with selector 0 loads {HI,LO} with the signed 64-bit product of the operands and asserts no register write.
- R3: Function code 0x19 treats both operands as unsigned and zero-extends them, for the plain multiply and for every extended variant.
- R4: Selectors 0x03 and 0x0B load {HI,LO} with zero minus the product, whatever HI and LO held before.
- R5: Selectors 0x05 and 0x0D load {HI,LO} with the old {HI,LO} plus the product, wrapping modulo 2^64.
- R6: Selectors 0x07 and 0x0F load {HI,LO} with the old {HI,LO} minus the product, wrapping modulo 2^64.
- R7: When an extended variant completes, `wb_en` is high and `wb_idx` is the destination index. `wb_data` is the new LO for selectors 0x03, 0x05 and 0x07, and the new HI for selectors 0x09, 0x0B, 0x0D and 0x0F.
- R8: Selector 0x09 loads {HI,LO} with the plain product and returns the new HI.
- R9: A nonzero selector outside {0x03,0x05,0x07,0x09,0x0B,0x0D,0x0F} raises `rsvd_insn`, leaves HI and LO unchanged and asserts no register write.
- R10: While `ext_enable` is low, every nonzero selector is treated as in R9.
- R11: An extended variant whose destination index is 0 updates HI and LO but keeps `wb_en` low.
- R12: `done` is high exactly in the cycle after each cycle in which `op_valid` is high, and HI/LO take their new value at the same edge. A function code other than 0x18 or 0x19 is treated as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_enable | input | 1 | Allows the extended selector variants |
| op_valid | input | 1 | Starts an operation this cycle |
| op_func | input | 6 | Function code: 0x18 signed, 0x19 unsigned |
| op_sel | input | 5 | Variant selector (instruction bits 10:6) |
| op_dest | input | 5 | Destination register index for the write-back |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| done | output | 1 | Operation finished (one cycle after `op_valid`) |
| rsvd_insn | output | 1 | Operation rejected as a reserved encoding |
| wb_en | output | 1 | Register-file write request |
| wb_idx | output | 5 | Register-file write index |
| wb_data | output | 32 | Register-file write value |
| hi_q | output | 32 | Current HI register |
| lo_q | output | 32 | Current LO register |

## Verification
HI and LO are visible on every cycle, so a wrong accumulator value shows on `hi_q`/`lo_q` one cycle after the faulty operation is issued. If it were ever hidden there, it would still surface at the next add or subtract variant, which carries the error into the result it writes back. Negate and plain variants wipe an earlier error from the accumulator. The tests therefore chain several accumulate operations and check the write-back value alongside HI and LO. A decode fault shows in that same cycle as a wrong `rsvd_insn` or `wb_en`, or as the wrong half on `wb_data`.

// File: rtl/mac_hilo_pkg.sv
package mac_hilo_pkg;

  localparam logic [5:0] FN_MUL_S = 6'h18;
  localparam logic [5:0] FN_MUL_U = 6'h19;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'b00,
    ACC_NEG  = 2'b01,
    ACC_ADD  = 2'b10,
    ACC_SUB  = 2'b11
  } acc_mode_e;

  typedef struct packed {
    logic      legal;
    logic      is_ext;
    logic      ret_hi;
    logic      uns;
    acc_mode_e mode;
  } mac_ctl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_hilo_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic [5:0]       func,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_en,
  output mac_ctl_t         ctl
);

  logic fn_known;
  logic sel_zero;
  logic sel_shape_ok;

  assign fn_known = (func == FN_MUL_S) || (func == FN_MUL_U);
  assign sel_zero = (sel == '0);

  // legal extended selectors: odd, upper bits clear, not the bare value 1
  generate
    if (SEL_W > 4) begin : g_wide
      assign sel_shape_ok = sel[0] && (sel[SEL_W-1:4] == '0) && (sel[3:1] != 3'b000);
    end else begin : g_narrow
      assign sel_shape_ok = sel[0] && (sel[3:1] != 3'b000);
    end
  endgenerate

  always_comb begin
    ctl.uns    = (func == FN_MUL_U);
    ctl.is_ext = !sel_zero;
    if (sel_zero) begin
      ctl.legal  = fn_known;
      ctl.ret_hi = 1'b0;
      ctl.mode   = ACC_LOAD;
    end else begin
      ctl.legal  = fn_known && ext_en && sel_shape_ok;
      ctl.ret_hi = sel[3];
      ctl.mode   = acc_mode_e'(sel[2:1]);
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_hilo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                uns,
  input  acc_mode_e           mode,
  input  logic [2*DATA_W-1:0] acc,
  output logic [2*DATA_W-1:0] product,
  output logic [2*DATA_W-1:0] result
);

  localparam int unsigned PW = 2 * DATA_W;

  function automatic logic [PW-1:0] widen(input logic [DATA_W-1:0] x, input logic u);
    return u ? {{DATA_W{1'b0}}, x} : {{DATA_W{x[DATA_W-1]}}, x};
  endfunction

  // low PW bits of the widened product give the exact signed or unsigned result
  function automatic logic [PW-1:0] wide_mul(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y,
                                             input logic u);
    logic [PW-1:0] xe;
    logic [PW-1:0] ye;
    xe = widen(x, u);
    ye = widen(y, u);
    return xe * ye;
  endfunction

  function automatic logic [PW-1:0] combine(input acc_mode_e m,
                                            input logic [PW-1:0] old_acc,
                                            input logic [PW-1:0] p);
    case (m)
      ACC_NEG: return '0 - p;
      ACC_ADD: return old_acc + p;
      ACC_SUB: return old_acc - p;
      default: return p;
    endcase
  endfunction

  assign product = wide_mul(a, b, uns);
  assign result  = combine(mode, acc, product);

endmodule

// File: rtl/mac_state.sv
module mac_state
  import mac_hilo_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                commit,
  input  logic                want_wb,
  input  logic                ret_hi,
  input  logic [IDX_W-1:0]    dest,
  input  logic [2*DATA_W-1:0] result,
  output logic [DATA_W-1:0]   hi,
  output logic [DATA_W-1:0]   lo,
  output logic                done,
  output logic                rsvd,
  output logic                wb_en,
  output logic [IDX_W-1:0]    wb_idx,
  output logic [DATA_W-1:0]   wb_data
);

  logic wr_go;
  assign wr_go = commit && want_wb && (dest != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi      <= '0;
      lo      <= '0;
      done    <= 1'b0;
      rsvd    <= 1'b0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      done  <= fire;
      rsvd  <= fire && !commit;
      wb_en <= wr_go;
      if (commit) begin
        hi <= result[2*DATA_W-1:DATA_W];
        lo <= result[DATA_W-1:0];
      end
      if (wr_go) begin
        wb_idx  <= dest;
        wb_data <= ret_hi ? result[2*DATA_W-1:DATA_W] : result[DATA_W-1:0];
      end else begin
        wb_idx  <= '0;
        wb_data <= '0;
      end
    end
  end

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_hilo_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_enable,
  input  logic              op_valid,
  input  logic [5:0]        op_func,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic [IDX_W-1:0]  op_dest,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              done,
  output logic              rsvd_insn,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q
);

  localparam int unsigned ACC_W = 2 * DATA_W;

  mac_ctl_t         ctl;
  logic [ACC_W-1:0] product;
  logic [ACC_W-1:0] next_acc;
  logic             hilo_commit;
  logic             op_reject;

  mac_decode #(.SEL_W(SEL_W)) u_dec (
    .func   (op_func),
    .sel    (op_sel),
    .ext_en (ext_enable),
    .ctl    (ctl)
  );

  mac_datapath #(.DATA_W(DATA_W)) u_dp (
    .a       (op_a),
    .b       (op_b),
    .uns     (ctl.uns),
    .mode    (ctl.mode),
    .acc     ({hi_q, lo_q}),
    .product (product),
    .result  (next_acc)
  );

  assign hilo_commit = op_valid && ctl.legal;
  assign op_reject   = op_valid && !ctl.legal;

  mac_state #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (op_valid),
    .commit  (hilo_commit),
    .want_wb (ctl.is_ext),
    .ret_hi  (ctl.ret_hi),
    .dest    (op_dest),
    .result  (next_acc),
    .hi      (hi_q),
    .lo      (lo_q),
    .done    (done),
    .rsvd    (rsvd_insn),
    .wb_en   (wb_en),
    .wb_idx  (wb_idx),
    .wb_data (wb_data)
  );

endmodule

// File: rtl/mac_hilo_checks.sv
module mac_hilo_checks #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_enable,
  input logic              op_valid,
  input logic [SEL_W-1:0]  op_sel,
  input logic              done,
  input logic              rsvd_insn,
  input logic              wb_en,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [DATA_W-1:0] wb_data,
  input logic [DATA_W-1:0] hi_q,
  input logic [DATA_W-1:0] lo_q,
  input logic              op_reject
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!rsvd_insn && !wb_en));

  a_r12_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done);

  a_r12_done_only_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done);

  a_r9_reject_holds_hilo: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |=> (hi_q == $past(hi_q) && lo_q == $past(lo_q)));

  a_r9_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_insn |-> !wb_en);

  a_r10_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ext_enable && op_sel != '0) |=> rsvd_insn);

  a_r2_plain_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == '0) |=> !wb_en);

  a_r11_no_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));

  a_r7_wb_is_half: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == hi_q || wb_data == lo_q));

endmodule

bind mac_hilo_unit mac_hilo_checks #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_enable (ext_enable),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .done       (done),
  .rsvd_insn  (rsvd_insn),
  .wb_en      (wb_en),
  .wb_idx     (wb_idx),
  .wb_data    (wb_data),
  .hi_q       (hi_q),
  .lo_q       (lo_q),
  .op_reject  (op_reject)
);

// File: tb/mac_hilo_unit_test.sv
module mac_hilo_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_enable = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  op_func = 6'h18;
  logic [4:0]  op_sel = 5'h0;
  logic [4:0]  op_dest = 5'h0;
  logic [31:0] op_a = 32'h0;
  logic [31:0] op_b = 32'h0;
  logic        done;
  logic        rsvd_insn;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic [31:0] hi_q;
  logic [31:0] lo_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] model_acc = 64'h0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac_hilo_unit uut (
    .clk(clk), .rst_n(rst_n), .ext_enable(ext_enable), .op_valid(op_valid),
    .op_func(op_func), .op_sel(op_sel), .op_dest(op_dest), .op_a(op_a), .op_b(op_b),
    .done(done), .rsvd_insn(rsvd_insn), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .hi_q(hi_q), .lo_q(lo_q)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // One operation: driven at a falling edge, results sampled at the next falling edge.
  task automatic run_op(input string tag, input logic [5:0] fn, input logic [4:0] code,
                        input logic [4:0] dst, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] xa, xb, prod, nxt;
    bit uns, fn_ok, known, ok, to_hi;
    int kind;  // 0 load, 1 negate, 2 add, 3 subtract
    uns   = (fn == 6'h19);
    fn_ok = (fn == 6'h18) || uns;
    known = 1; kind = 0; to_hi = 0;
    case (code)
      5'h00: begin kind = 0; end
      5'h03: begin kind = 1; end
      5'h05: begin kind = 2; end
      5'h07: begin kind = 3; end
      5'h09: begin kind = 0; to_hi = 1; end
      5'h0B: begin kind = 1; to_hi = 1; end
      5'h0D: begin kind = 2; to_hi = 1; end
      5'h0F: begin kind = 3; to_hi = 1; end
      default: known = 0;
    endcase
    ok = fn_ok && (code == 0 || (known && ext_enable));
    xa = uns ? {32'h0, a} : {{32{a[31]}}, a};
    xb = uns ? {32'h0, b} : {{32{b[31]}}, b};
    prod = xa * xb;
    case (kind)
      1: nxt = 64'h0 - prod;
      2: nxt = model_acc + prod;
      3: nxt = model_acc - prod;
      default: nxt = prod;
    endcase
    if (ok) model_acc = nxt;

    op_valid = 1'b1; op_func = fn; op_sel = code; op_dest = dst; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    chk(tag, "done", {63'h0, done}, 64'h1);
    chk(tag, "rsvd", {63'h0, rsvd_insn}, {63'h0, !ok});
    chk(tag, "hilo", {hi_q, lo_q}, model_acc);
    chk(tag, "wb_en", {63'h0, wb_en}, {63'h0, ok && code != 0 && dst != 0});
    if (ok && code != 0 && dst != 0) begin
      chk(tag, "wb_idx", {59'h0, wb_idx}, {59'h0, dst});
      chk(tag, "wb_data", {32'h0, wb_data}, {32'h0, to_hi ? model_acc[63:32] : model_acc[31:0]});
    end
  endtask

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    chk(tag, "idle done", {63'h0, done}, 64'h0);
    chk(tag, "idle wb_en", {63'h0, wb_en}, 64'h0);
    chk(tag, "idle hilo", {hi_q, lo_q}, model_acc);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] codes [16];
    codes = '{5'h00, 5'h03, 5'h05, 5'h07, 5'h09, 5'h0B, 5'h0D, 5'h0F,
              5'h01, 5'h02, 5'h04, 5'h11, 5'h13, 5'h1F, 5'h0E, 5'h08};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "hi", {32'h0, hi_q}, 64'h0);
    chk("R1", "lo", {32'h0, lo_q}, 64'h0);
    chk("R1", "flags", {61'h0, done, rsvd_insn, wb_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R2", 6'h18, 5'h00, 5'd4, 32'hFFFF_FFFD, 32'd5);
    run_op("R2", 6'h18, 5'h00, 5'd4, 32'h8000_0000, 32'h8000_0000);
    run_op("R3", 6'h19, 5'h00, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle_cycle("R12");
    run_op("R5", 6'h18, 5'h05, 5'd7, 32'hFFFF_FFFF, 32'd3);
    run_op("R5", 6'h19, 5'h05, 5'd7, 32'hFFFF_FFFF, 32'd3);
    run_op("R5", 6'h19, 5'h0D, 5'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R6", 6'h18, 5'h07, 5'd2, 32'd1000, 32'hFFFF_FF00);
    run_op("R6", 6'h19, 5'h0F, 5'd3, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op("R4", 6'h18, 5'h03, 5'd5, 32'd6, 32'd7);
    run_op("R4", 6'h19, 5'h0B, 5'd5, 32'hFFFF_FFFF, 32'd2);
    run_op("R8", 6'h18, 5'h09, 5'd6, 32'hFFFF_FFFF, 32'd1);
    run_op("R7", 6'h19, 5'h09, 5'd6, 32'hDEAD_BEEF, 32'h1000);
    run_op("R9", 6'h18, 5'h01, 5'd8, 32'd9, 32'd9);
    run_op("R9", 6'h18, 5'h04, 5'd8, 32'd9, 32'd9);
    run_op("R9", 6'h19, 5'h13, 5'd8, 32'd9, 32'd9);
    run_op("R9", 6'h18, 5'h1F, 5'd8, 32'd9, 32'd9);
    ext_enable = 1'b0;
    run_op("R10", 6'h18, 5'h05, 5'd8, 32'd11, 32'd11);
    run_op("R10", 6'h19, 5'h09, 5'd8, 32'd11, 32'd11);
    run_op("R10", 6'h19, 5'h00, 5'd8, 32'd11, 32'd13);
    ext_enable = 1'b1;
    run_op("R11", 6'h18, 5'h05, 5'd0, 32'd100, 32'd100);
    run_op("R11", 6'h18, 5'h0D, 5'd0, 32'hFFFF_FFFF, 32'd100);
    run_op("R12", 6'h1A, 5'h00, 5'd1, 32'd3, 32'd3);
    run_op("R12", 6'h1A, 5'h05, 5'd1, 32'd3, 32'd3);
    idle_cycle("R12");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] c;
      c = codes[$urandom_range(15, 0)];
      ext_enable = ($urandom_range(7, 0) != 0);
      run_op("R7", ($urandom_range(1, 0) == 1) ? 6'h19 : 6'h18, c,
             5'($urandom_range(31, 0)), $urandom, $urandom);
      if ($urandom_range(3, 0) == 0) idle_cycle("R12");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule